// File: doc/BRIEF.md
# Dual-Rail Channel Codec with Completion Detection

This block is a clocked model of a delay-insensitive data channel in which every data bit travels on two wires. The sending half takes a single-rail word through a valid/ready handshake and places it on the rail pairs. It holds the word until the far end acknowledges it, and then returns every rail to the empty (spacer) state before it will accept another word. A spacer therefore always separates two words, even when the two words are equal.

The receiving half watches the rail pairs. A completion detector models a tree of C-elements. Its `rx_done` output rises only when every bit carries a legal code. It falls only when every bit is back to spacer. In any mixed state it keeps its previous value. The decoded word is captured when `rx_done` rises and is held while `rx_done` stays high. A pair with both rails high is illegal and raises a sticky error. The two halves are independent, so a system normally wires `rx_done` of one end back to `tx_ack` of the other end.

Top module: `dr_channel_codec`

## Requirements
- R1: Bit i of a sent word appears on pair i as `tx_rail_t[i]`=1, `tx_rail_f[i]`=0 for a one, and as `tx_rail_t[i]`=0, `tx_rail_f[i]`=1 for a zero. The sender never drives both rails of a pair high.
- R2: The sender puts a word on the rails in the cycle after a valid/ready handshake. It holds that word unchanged until `tx_ack` is seen high.
- R3: After seeing `tx_ack` high, the sender drives all rails low (spacer) in the next cycle. Every word on the rails is preceded by an all-spacer state, including a repeat of the same value.
- R4: `tx_ready` is high only while the sender is driving spacer and `tx_ack` is low.
- R5: `rx_done` rises one cycle after every pair holds a legal code (exactly one rail high). It does not rise while any pair is spacer or illegal.
- R6: `rx_done` falls one cycle after every pair is spacer (both rails low). In any other state it keeps its previous value.
- R7: `rx_data` takes the true rails in the cycle where `rx_done` rises. It stays unchanged for as long as `rx_done` is high.
- R8: A pair with both rails high sets `rx_err`. `rx_err` stays high until reset, and such a pair does not count as valid.
- R9: While reset is active, `rx_done`, `rx_data` and `rx_err` are 0, all transmit rails are low, and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | A word is offered for sending |
| tx_word | input | W | Single-rail word to send |
| tx_ready | output | 1 | Sender can take a word |
| tx_ack | input | 1 | Acknowledge from the far end's completion |
| tx_rail_t | output | W | Transmit true rails |
| tx_rail_f | output | W | Transmit false rails |
| rx_rail_t | input | W | Receive true rails |
| rx_rail_f | input | W | Receive false rails |
| rx_done | output | 1 | Completion with hysteresis |
| rx_data | output | W | Decoded word |
| rx_err | output | 1 | Sticky illegal-code flag |

## Verification
The embedded properties check several rules on every cycle. The sender never drives an illegal pair. It holds its word until acknowledged and falls to spacer straight after. Each edge of `rx_done` is preceded by the matching all-valid or all-spacer input, the decoded word is frozen while complete, and the error never clears by itself. Other behaviour only the bench scenarios can show. These are the hysteresis through partly valid and partly empty inputs, an illegal pair blocking completion, the insertion of a spacer between equal words, and the end-to-end word ordering in loopback. The bench shows these against a behavioural model that counts valid and empty pairs.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef enum logic {
        ENC_SPACER = 1'b0,
        ENC_WORD   = 1'b1
    } enc_state_e;

endpackage

// File: rtl/dr_enc.sv
module dr_enc
    import dr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         snd_valid,
    input  logic [W-1:0] snd_word,
    output logic         snd_ready,
    input  logic         ack,
    output logic [W-1:0] rail_t,
    output logic [W-1:0] rail_f
);

    typedef struct packed {
        enc_state_e   st;
        logic [W-1:0] word;
        logic [W-1:0] rt;
        logic [W-1:0] rf;
    } enc_regs_t;

    enc_regs_t regs_d, regs_q;

    assign snd_ready = (regs_q.st == ENC_SPACER) && !ack;

    always_comb begin
        regs_d = regs_q;
        case (regs_q.st)
            ENC_SPACER: begin
                if (snd_valid && snd_ready) begin
                    regs_d.st   = ENC_WORD;
                    regs_d.word = snd_word;
                end
            end
            ENC_WORD: begin
                if (ack) begin
                    regs_d.st = ENC_SPACER;
                end
            end
            default: regs_d.st = ENC_SPACER;
        endcase
        if (regs_d.st == ENC_WORD) begin
            regs_d.rt = regs_d.word;
            regs_d.rf = ~regs_d.word;
        end else begin
            regs_d.rt = '0;
            regs_d.rf = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ENC_SPACER, word: '0, rt: '0, rf: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rail_t = regs_q.rt;
    assign rail_f = regs_q.rf;

    AST_ENC_NO_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_t & rail_f) == '0); // R1

    AST_ENC_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ENC_WORD && !ack) |=> ($stable(rail_t) && $stable(rail_f))); // R2

    AST_ENC_SPACER_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ENC_WORD && ack) |=> (rail_t == '0 && rail_f == '0)); // R3

    AST_ENC_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        snd_ready |-> (rail_t == '0 && rail_f == '0 && !ack)); // R4

endmodule

// File: rtl/dr_cdet.sv
module dr_cdet #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rail_t,
    input  logic [W-1:0] rail_f,
    output logic         all_valid,
    output logic         any_bad,
    output logic         done
);

    logic [W-1:0] bit_valid;
    logic [W-1:0] bit_null;
    logic [W-1:0] bit_bad;
    logic         all_null;
    logic         done_d, done_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_valid[i] = rail_t[i] ^ rail_f[i];
        assign bit_null[i]  = ~(rail_t[i] | rail_f[i]);
        assign bit_bad[i]   = rail_t[i] & rail_f[i];
    end

    assign all_valid = &bit_valid;
    assign all_null  = &bit_null;
    assign any_bad   = |bit_bad;

    always_comb begin
        done_d = done_q;
        if (all_valid) begin
            done_d = 1'b1;
        end else if (all_null) begin
            done_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_d;
        end
    end

    assign done = done_q;

    AST_DONE_RISE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(all_valid)); // R5

    AST_DONE_FALL_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_q) |-> $past(all_null)); // R6

endmodule

// File: rtl/dr_dec.sv
module dr_dec #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rail_t,
    input  logic [W-1:0] rail_f,
    output logic         done,
    output logic [W-1:0] data,
    output logic         err
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         err;
    } dec_regs_t;

    dec_regs_t regs_d, regs_q;
    logic      all_valid;
    logic      any_bad;

    dr_cdet #(.W(W)) u_cdet (
        .clk       (clk),
        .rst_n     (rst_n),
        .rail_t    (rail_t),
        .rail_f    (rail_f),
        .all_valid (all_valid),
        .any_bad   (any_bad),
        .done      (done)
    );

    always_comb begin
        regs_d = regs_q;
        if (all_valid && !done) begin
            regs_d.data = rail_t;
        end
        if (any_bad) begin
            regs_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{data: '0, err: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign data = regs_q.data;
    assign err  = regs_q.err;

    AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (data == $past(rail_t))); // R7

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done -> $stable(data))); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R8

    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        any_bad |=> err); // R8

endmodule

// File: rtl/dr_channel_codec.sv
module dr_channel_codec #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_word,
    output logic         tx_ready,
    input  logic         tx_ack,
    output logic [W-1:0] tx_rail_t,
    output logic [W-1:0] tx_rail_f,
    input  logic [W-1:0] rx_rail_t,
    input  logic [W-1:0] rx_rail_f,
    output logic         rx_done,
    output logic [W-1:0] rx_data,
    output logic         rx_err
);

    dr_enc #(.W(W)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .snd_valid (tx_valid),
        .snd_word  (tx_word),
        .snd_ready (tx_ready),
        .ack       (tx_ack),
        .rail_t    (tx_rail_t),
        .rail_f    (tx_rail_f)
    );

    dr_dec #(.W(W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .rail_t (rx_rail_t),
        .rail_f (rx_rail_f),
        .done   (rx_done),
        .data   (rx_data),
        .err    (rx_err)
    );

endmodule

// File: tb/dr_channel_codec_tb.sv
module dr_channel_codec_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_valid = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         tx_ready;
    logic         tx_ack;
    logic [W-1:0] tx_rail_t, tx_rail_f;
    logic [W-1:0] rx_rail_t, rx_rail_f;
    logic         rx_done;
    logic [W-1:0] rx_data;
    logic         rx_err;

    logic         direct = 1'b0;
    logic [W-1:0] drv_t = '0;
    logic [W-1:0] drv_f = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign rx_rail_t = direct ? drv_t : tx_rail_t;
    assign rx_rail_f = direct ? drv_f : tx_rail_f;
    assign tx_ack    = direct ? 1'b0  : rx_done;

    dr_channel_codec #(.W(W)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .tx_valid (tx_valid), .tx_word (tx_word), .tx_ready (tx_ready),
        .tx_ack (tx_ack), .tx_rail_t (tx_rail_t), .tx_rail_f (tx_rail_f),
        .rx_rail_t (rx_rail_t), .rx_rail_f (rx_rail_f),
        .rx_done (rx_done), .rx_data (rx_data), .rx_err (rx_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural receiver model
    logic         m_done = 1'b0;
    logic [W-1:0] m_data = '0;
    logic         m_err = 1'b0;
    int           n_valid, n_empty, n_bad;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_done = 1'b0; m_data = '0; m_err = 1'b0;
        end else begin
            n_valid = 0; n_empty = 0; n_bad = 0;
            for (int i = 0; i < W; i++) begin
                if (rx_rail_t[i] && rx_rail_f[i]) n_bad++;
                else if (rx_rail_t[i] || rx_rail_f[i]) n_valid++;
                else n_empty++;
            end
            if (n_valid == W) begin
                if (!m_done) m_data = rx_rail_t;
                m_done = 1'b1;
            end else if (n_empty == W) begin
                m_done = 1'b0;
            end
            if (n_bad > 0) m_err = 1'b1;
        end
    end

    // sender observation
    logic [W-1:0] exp_q[$];
    bit           seen_spacer = 1'b1;
    bit           prev_full = 1'b0;
    bit           tx_full, tx_empty;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(rx_done == m_done, "R5 R6 done", rx_done, m_done);
            chk(rx_data == m_data, "R7 data", rx_data, m_data);
            chk(rx_err == m_err, "R8 err", rx_err, m_err);
            chk((tx_rail_t & tx_rail_f) == '0, "R1 no illegal pair", tx_rail_t & tx_rail_f, 0);
            tx_full  = ((tx_rail_t ^ tx_rail_f) == {W{1'b1}});
            tx_empty = ((tx_rail_t | tx_rail_f) == '0);
            chk(tx_full || tx_empty, "R2 rails whole word or spacer", tx_rail_t, tx_rail_f);
            if (tx_empty) seen_spacer = 1'b1;
            if (tx_full && !prev_full) begin
                chk(seen_spacer, "R3 spacer before word", 0, 1);
                if (exp_q.size() > 0) begin
                    chk(tx_rail_t == exp_q[0], "R1 word encoding", tx_rail_t, exp_q[0]);
                    void'(exp_q.pop_front());
                end else begin
                    chk(1'b0, "R2 unexpected word", tx_rail_t, 0);
                end
                seen_spacer = 1'b0;
            end
            prev_full = tx_full;
        end
    end

    task automatic send(input logic [W-1:0] w);
        tx_valid = 1'b1;
        tx_word  = w;
        while (!tx_ready) @(negedge clk);
        exp_q.push_back(w);
        @(negedge clk);
        tx_valid = 1'b0;
        chk(!tx_ready, "R4 ready low after accept", tx_ready, 0);
        // wait until the word has been consumed and the sender is idle again
        while (!tx_ready) @(negedge clk);
    endtask

    task automatic drive(input logic [W-1:0] t, input logic [W-1:0] f, input int cycles);
        drv_t = t;
        drv_f = f;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic reset_check();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(rx_done == 1'b0, "R9 reset done", rx_done, 0);
        chk(rx_data == '0, "R9 reset data", rx_data, 0);
        chk(rx_err == 1'b0, "R9 reset err", rx_err, 0);
        chk(tx_rail_t == '0 && tx_rail_f == '0, "R9 reset rails", tx_rail_t, 0);
        chk(tx_ready == 1'b1, "R9 reset ready", tx_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        reset_check();

        // loopback: sender feeds receiver, completion acknowledges sender
        send(8'hA5);
        send(8'hA5);
        send(8'h00);
        send(8'hFF);
        send(8'h3C);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all words delivered", exp_q.size(), 0);

        // direct drive of the receiver
        direct = 1'b1;
        drive('0, '0, 2);
        drive(8'h0F, 8'h00, 3);            // partly valid: R5 no rise
        chk(!rx_done, "R5 no rise on partial", rx_done, 0);
        drive(8'h5A, 8'hA5, 2);            // all valid
        chk(rx_done && rx_data == 8'h5A, "R5 R7 rise and capture", rx_data, 8'h5A);
        drive(8'h50, 8'hA0, 3);            // partly empty: R6 hold
        chk(rx_done && rx_data == 8'h5A, "R6 R7 hold on partial spacer", rx_data, 8'h5A);
        drive('0, '0, 2);
        chk(!rx_done, "R6 fall on all spacer", rx_done, 0);
        drive(8'hC3, 8'h3C, 2);
        chk(rx_data == 8'hC3, "R7 second capture", rx_data, 8'hC3);
        drive('0, '0, 2);
        drive(8'hFF, 8'h01, 3);            // pair 0 illegal
        chk(rx_err && !rx_done, "R8 illegal sets err, blocks done", {rx_err, rx_done}, 2'b10);
        drive('0, '0, 3);
        chk(rx_err, "R8 err sticky", rx_err, 1);
        reset_check();
        chk(!rx_err, "R8 err cleared only by reset", rx_err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule